// File: doc/BRIEF.md
# Secure Trap Mode Controller

This block turns a fault alarm from the chip's detectors into a secure trap that cannot be masked. It tracks whether the processor runs in nominal mode or in safe mode. An alarm seen in nominal mode moves the block to safe mode on the next clock edge. On that edge it annuls every instruction in flight, blocks commits from the user program to the register file and memory, and freezes the recovery registers. It also redirects fetch to the first handler instruction and stores the interrupted instruction's address for the handler.

Safe mode ends only when the handler reports that it has finished and no alarm arrives in the same cycle. An alarm during safe mode does not nest and is not dropped. It restarts the handler from its first instruction. The handler therefore has to run to completion without a fault before the user program gets control back.

Top module: `secure_trap_ctrl`

## Requirements
- R1: After reset, safe_mode_o, annul_o, user_wr_inhibit_o, frr_freeze_o, redirect_vld_o, link_we_o are 0, and redirect_pc_o and link_pc_o are 0.
- R2: When alarm_i is high at a clock edge in nominal mode, safe_mode_o is 1 from that edge on.
- R3: annul_o is high for exactly the one cycle after each edge that samples alarm_i high, in either mode.
- R4: user_wr_inhibit_o equals safe_mode_o. It gates user-program commits only; handler writes are not routed through this block.
- R5: frr_freeze_o is high in every cycle spent in safe mode, from the entry cycle onward.
- R6: redirect_vld_o pulses for one cycle after each sampled alarm, with redirect_pc_o equal to parameter TRAP_VEC (default 32'h0000_0100). In every other cycle redirect_pc_o is 0.
- R7: On entry to safe mode, link_we_o pulses for one cycle and link_pc_o takes the fault_pc_i value sampled with the alarm. link_pc_o holds that value until the next entry.
- R8: handler_done_i high at an edge in safe mode with alarm_i low returns to nominal mode after that edge, and R4 and R5 outputs drop.
- R9: An alarm in safe mode keeps the block in safe mode and repeats the annul and redirect pulses. It does not pulse link_we_o and leaves link_pc_o unchanged.
- R10: When handler_done_i and alarm_i are high at the same edge in safe mode, the alarm wins: the mode stays safe and the handler restarts as in R9.
- R11: handler_done_i in nominal mode has no effect on any output.
- R12: No input masks the trap: alarms on consecutive cycles each produce their own annul and redirect pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alarm_i | input | 1 | Fault alarm from detectors |
| handler_done_i | input | 1 | Trap handler reports completion |
| fault_pc_i | input | PC_W | Address of the instruction being interrupted |
| annul_o | output | 1 | Kill all in-flight instructions |
| user_wr_inhibit_o | output | 1 | Block user-program register-file and memory commits |
| frr_freeze_o | output | 1 | Hold the recovery registers |
| redirect_vld_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | PC_W | Handler entry address while redirect is valid |
| link_we_o | output | 1 | Write strobe for the handler-local return register |
| link_pc_o | output | PC_W | Saved interrupted address |
| safe_mode_o | output | 1 | 1 in safe mode, 0 in nominal mode |

## Verification
If the mode register holds the wrong value, it shows on the same cycle at safe_mode_o, user_wr_inhibit_o and frr_freeze_o. One cycle after the next alarm it also shows at link_we_o, which pulses only on entry. If the pulse logic is wrong, the fault shows within one cycle of an alarm at annul_o or redirect_vld_o. The same-edge handler-done and alarm case is the likeliest to hide a priority bug, and it shows as a premature drop of safe_mode_o one cycle later.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic {MODE_NOMINAL = 1'b0, MODE_SAFE = 1'b1} stc_mode_e;

  // Next mode: alarm always forces safe; done leaves safe only when no alarm
  function automatic stc_mode_e stc_next_mode(stc_mode_e cur, logic alarm, logic done);
    stc_mode_e nxt;
    nxt = cur;
    if (alarm)
      nxt = MODE_SAFE;
    else if (cur == MODE_SAFE && done)
      nxt = MODE_NOMINAL;
    return nxt;
  endfunction

  // Entry into safe mode happens only from nominal
  function automatic logic stc_is_entry(stc_mode_e cur, logic alarm);
    return alarm && (cur == MODE_NOMINAL);
  endfunction

  // Restart of the handler happens on an alarm inside safe mode
  function automatic logic stc_is_restart(stc_mode_e cur, logic alarm);
    return alarm && (cur == MODE_SAFE);
  endfunction
endpackage

// File: rtl/stc_mode_fsm.sv
module stc_mode_fsm
  import stc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      alarm_i,
  input  logic      done_i,
  output stc_mode_e mode_o
);
  stc_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NOMINAL;
    else        mode_q <= stc_next_mode(mode_q, alarm_i, done_i);
  end

  assign mode_o = mode_q;

  // R2
  entry_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_i && mode_q == MODE_NOMINAL) |=> (mode_q == MODE_SAFE));
  // R8
  exit_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SAFE && done_i && !alarm_i) |=> (mode_q == MODE_NOMINAL));
  // R10
  alarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SAFE && alarm_i) |=> (mode_q == MODE_SAFE));
endmodule

// File: rtl/stc_trap_pulse.sv
module stc_trap_pulse #(
  parameter int          PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic            entry_i,
  input  logic [PC_W-1:0] fault_pc_i,
  output logic            annul_o,
  output logic            redirect_vld_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            link_we_o,
  output logic [PC_W-1:0] link_pc_o
);
  logic            fire_q;
  logic            link_we_q;
  logic [PC_W-1:0] link_pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q    <= 1'b0;
      link_we_q <= 1'b0;
      link_pc_q <= '0;
    end else begin
      fire_q    <= fire_i;
      link_we_q <= entry_i;
      if (entry_i) link_pc_q <= fault_pc_i;
    end
  end

  assign annul_o        = fire_q;
  assign redirect_vld_o = fire_q;
  assign redirect_pc_o  = fire_q ? TRAP_VEC : '0;
  assign link_we_o      = link_we_q;
  assign link_pc_o      = link_pc_q;

  // R3
  annul_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> annul_o);
  // R6
  redirect_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_vld_o && !fire_i) |=> !redirect_vld_o);
  // R7
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_i |=> $stable(link_pc_o));
endmodule

// File: rtl/secure_trap_ctrl.sv
module secure_trap_ctrl
  import stc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alarm_i,
  input  logic            handler_done_i,
  input  logic [PC_W-1:0] fault_pc_i,
  output logic            annul_o,
  output logic            user_wr_inhibit_o,
  output logic            frr_freeze_o,
  output logic            redirect_vld_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            link_we_o,
  output logic [PC_W-1:0] link_pc_o,
  output logic            safe_mode_o
);
  stc_mode_e mode;
  logic      ev_entry;
  logic      ev_restart;
  logic      ev_exit;

  assign ev_entry   = stc_is_entry(mode, alarm_i);
  assign ev_restart = stc_is_restart(mode, alarm_i);
  assign ev_exit    = (mode == MODE_SAFE) && handler_done_i && !alarm_i;

  stc_mode_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .alarm_i(alarm_i),
    .done_i (handler_done_i),
    .mode_o (mode)
  );

  stc_trap_pulse #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) u_pulse (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire_i        (ev_entry | ev_restart),
    .entry_i       (ev_entry),
    .fault_pc_i    (fault_pc_i),
    .annul_o       (annul_o),
    .redirect_vld_o(redirect_vld_o),
    .redirect_pc_o (redirect_pc_o),
    .link_we_o     (link_we_o),
    .link_pc_o     (link_pc_o)
  );

  assign safe_mode_o       = (mode == MODE_SAFE);
  assign user_wr_inhibit_o = safe_mode_o;
  assign frr_freeze_o      = safe_mode_o;

  // R9
  restart_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restart |=> (!link_we_o && redirect_vld_o && safe_mode_o));
  // R5
  freeze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry |=> (frr_freeze_o && user_wr_inhibit_o));
  // R8
  exit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exit |=> (!frr_freeze_o && !user_wr_inhibit_o));
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!safe_mode_o && !alarm_i) |=> (!safe_mode_o && !annul_o));
endmodule

// File: tb/secure_trap_ctrl_bench.sv
module secure_trap_ctrl_bench;
  localparam int          PC_W = 32;
  localparam logic [31:0] VEC  = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm = 1'b0, done = 1'b0;
  logic [PC_W-1:0] fpc = '0;
  logic annul, inhib, frz, rvld, lwe, safe;
  logic [PC_W-1:0] rpc, lpc;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_safe = 0, m_pulse = 0, m_lwe = 0;
  logic [PC_W-1:0] m_lpc = '0;

  always #2.5 clk = ~clk;

  secure_trap_ctrl u_secure_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .handler_done_i(done),
    .fault_pc_i(fpc), .annul_o(annul), .user_wr_inhibit_o(inhib),
    .frr_freeze_o(frz), .redirect_vld_o(rvld), .redirect_pc_o(rpc),
    .link_we_o(lwe), .link_pc_o(lpc), .safe_mode_o(safe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R2 mode"}, {31'b0, safe}, m_safe);
    chk({tag, " R3 annul"}, {31'b0, annul}, m_pulse);
    chk({tag, " R4 inhibit"}, {31'b0, inhib}, m_safe);
    chk({tag, " R5 freeze"}, {31'b0, frz}, m_safe);
    chk({tag, " R6 redirect"}, {31'b0, rvld}, m_pulse);
    chk({tag, " R6 vector"}, rpc, (m_pulse != 0) ? VEC : 32'h0);
    chk({tag, " R7 link_we"}, {31'b0, lwe}, m_lwe);
    chk({tag, " R7 link_pc"}, lpc, m_lpc);
  endtask

  // apply inputs at negedge, advance one edge, update the model, compare at negedge
  task automatic step(input logic a, input logic d, input logic [31:0] pc, input string tag);
    alarm = a; done = d; fpc = pc;
    @(posedge clk);
    m_pulse = a ? 1 : 0;
    m_lwe = 0;
    if (a && m_safe == 0) begin
      m_safe = 1; m_lwe = 1; m_lpc = pc;
    end else if (!a && d && m_safe == 1) begin
      m_safe = 0;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    step(0, 0, 32'h0, "R1 idle");
    step(0, 1, 32'h0, "R11 done nominal");
    step(0, 1, 32'h0, "R11 done nominal2");
    step(1, 0, 32'h0000_1234, "R2 entry");
    step(0, 0, 32'h0, "R5 hold safe");
    step(0, 0, 32'h0, "R5 hold safe2");
    step(1, 0, 32'h0000_9999, "R9 restart");
    step(0, 0, 32'h0, "R9 after");
    step(1, 1, 32'h0000_7777, "R10 tie");
    step(0, 1, 32'h0, "R8 exit");
    step(0, 0, 32'h0, "R8 nominal");
    step(1, 0, 32'h0000_ABCD, "R12 a1");
    step(1, 0, 32'h0000_1111, "R12 a2");
    step(1, 1, 32'h0000_2222, "R12 a3");
    step(0, 0, 32'h0, "R12 end");
    step(0, 1, 32'h0, "R8 exit2");
    // a second user run with pseudo-random traffic
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = (i * 32'h9E37_79B9) ^ (i << 7);
      step(r[3:0] == 4'h5, r[9], r ^ 32'h55AA_0000, "R12 mix");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule